// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Direction History

This block sits beside the fetch stage of a pipelined core and guesses, in the same cycle a fetch address is presented, whether the instruction there is a taken branch and where it goes. It is a direct-mapped table of sixteen entries. Each entry keeps a tag, the last known destination of the branch, and a four-state saturating direction history. Fetch also supplies the sign of the branch offset. When the table holds no entry for the address, the block uses that sign as a fixed rule: a backward branch is guessed taken and a forward branch is guessed not taken.

When a branch resolves later in the pipeline, the resolve port reports the branch address, whether it was taken and its real destination. A matching entry is trained by this report. On a miss, the report overwrites the entry at that index and seeds it with a weak state in the reported direction. A lookup always reads the table as it stood before the clock edge. A resolve that lands in the same cycle as a lookup of the same entry is therefore seen only from the next cycle on.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is empty: every lookup reports `pred_hit_o` = 0.
- R2: On a lookup miss, `pred_taken_o` equals `fetch_back_i`. Whenever `pred_taken_o` is 0, `pred_target_o` is `fetch_pc_i` + 4.
- R3: A resolve that misses allocates the entry at index PC[5:2] with tag PC[31:6] and the resolved target. Its state is Weakly Taken if the branch was taken and Weakly Not Taken otherwise. The next lookup of that PC hits, and it predicts taken (with the stored target) exactly when the branch was taken.
- R4: An entry in Strongly Not Taken that resolves taken moves to Weakly Not Taken and still predicts not taken.
- R5: Weakly Not Taken moves to Strongly Not Taken on a not-taken outcome and to Weakly Taken on a taken outcome. Weakly Taken moves to Strongly Taken on a taken outcome and to Weakly Not Taken on a not-taken outcome.
- R6: Strongly Taken stays there on a taken outcome, and Strongly Not Taken stays there on a not-taken outcome.
- R7: On a hit, the prediction depends only on the state: the two taken states predict taken and the two not-taken states predict not taken. `fetch_back_i` has no effect.
- R8: A lookup whose tag differs from the entry at its index misses. Resolving that PC replaces the entry, so the previous owner misses afterwards.
- R9: A lookup in the same cycle as a resolve to the same entry returns the entry's old contents. The update is visible from the next cycle.
- R10: A taken resolve on a hit writes the resolved target. A not-taken resolve leaves the stored target unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_pc_i | input | 32 | Address being fetched |
| fetch_back_i | input | 1 | Branch offset is negative (backward branch) |
| pred_hit_o | output | 1 | A table entry matches the fetch address |
| pred_taken_o | output | 1 | Guessed direction |
| pred_target_o | output | 32 | Next fetch address: stored target when guessed taken on a hit, else fetch address + 4 |
| upd_valid_i | input | 1 | A resolved branch is reported this cycle |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual direction of the resolved branch |
| upd_target_i | input | 32 | Actual destination of the resolved branch |

## Verification
A lookup and a training update can hit the same entry in the same clock cycle. The bench provokes this by holding a fetch address and a resolve to that address on the ports together for one cycle, before the edge. It first requires the output to show the entry's prior contents (a miss, with the static guess). After the edge it requires the newly allocated state and target. The state walks are judged from the predicted direction alone: each state is told apart from its neighbours by the direction predicted after a further, chosen outcome.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    DIR_SNT = 2'b00,
    DIR_WNT = 2'b01,
    DIR_WT  = 2'b10,
    DIR_ST  = 2'b11
  } dir_e;

  function automatic dir_e dir_next(input dir_e cur, input logic taken);
    unique case (cur)
      DIR_SNT: dir_next = taken ? DIR_WNT : DIR_SNT;
      DIR_WNT: dir_next = taken ? DIR_WT  : DIR_SNT;
      DIR_WT:  dir_next = taken ? DIR_ST  : DIR_WNT;
      default: dir_next = taken ? DIR_ST  : DIR_WT;
    endcase
  endfunction

  function automatic logic dir_taken(input dir_e cur);
    dir_taken = (cur == DIR_WT) || (cur == DIR_ST);
  endfunction

endpackage

// File: rtl/btb_entry.sv
module btb_entry
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int TAG_W = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             taken_i,
  input  logic [PC_W-1:0]  tgt_i,
  output logic             vld_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [PC_W-1:0]  tgt_o,
  output dir_e             st_o
);

  logic             vld_q;
  logic [TAG_W-1:0] tag_q;
  logic [PC_W-1:0]  tgt_q;
  dir_e             st_q;
  logic             own_w;

  assign own_w = vld_q && (tag_q == tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      tag_q <= '0;
      tgt_q <= '0;
      st_q  <= DIR_WNT;
    end else if (we_i) begin
      if (own_w) begin
        st_q <= dir_next(st_q, taken_i);
        if (taken_i) tgt_q <= tgt_i;
      end else begin
        vld_q <= 1'b1;
        tag_q <= tag_i;
        tgt_q <= tgt_i;
        st_q  <= taken_i ? DIR_WT : DIR_WNT;
      end
    end
  end

  assign vld_o = vld_q;
  assign tag_o = tag_q;
  assign tgt_o = tgt_q;
  assign st_o  = st_q;

  // R3
  alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> vld_q && (tag_q == $past(tag_i)));

  // R4
  snt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && own_w && st_q == DIR_SNT && taken_i) |=> st_q == DIR_WNT);

  // R6
  st_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && own_w && st_q == DIR_ST && taken_i) |=> st_q == DIR_ST);

  // R6
  snt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && own_w && st_q == DIR_SNT && !taken_i) |=> st_q == DIR_SNT);

  // R10
  keep_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && own_w && !taken_i) |=> $stable(tgt_q));

  // R9
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(vld_q) && $stable(tgt_q) && $stable(st_q) && $stable(tag_q));

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int TAG_W = 26,
  localparam int N    = 1 << IDX_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [TAG_W-1:0]        tag_i,
  input  logic [PC_W-1:0]         seq_pc_i,
  input  logic                    back_i,
  input  logic [N-1:0]            vld_i,
  input  logic [N-1:0][TAG_W-1:0] tag_a_i,
  input  logic [N-1:0][PC_W-1:0]  tgt_a_i,
  input  logic [N-1:0][1:0]       st_a_i,
  output logic                    hit_o,
  output logic                    taken_o,
  output logic [PC_W-1:0]         tgt_o
);

  dir_e sel_st;

  always_comb begin
    sel_st  = dir_e'(st_a_i[idx_i]);
    hit_o   = vld_i[idx_i] && (tag_a_i[idx_i] == tag_i);
    taken_o = hit_o ? dir_taken(sel_st) : back_i;
    tgt_o   = (hit_o && taken_o) ? tgt_a_i[idx_i] : seq_pc_i;
  end

  // R2
  seq_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken_o |-> tgt_o == seq_pc_i);

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 4,
  parameter int ALIGN_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  input  logic            fetch_back_i,
  output logic            pred_hit_o,
  output logic            pred_taken_o,
  output logic [PC_W-1:0] pred_target_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic [PC_W-1:0] upd_target_i
);

  localparam int N     = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W - ALIGN_W;

  logic [IDX_W-1:0] f_idx, u_idx;
  logic [TAG_W-1:0] f_tag, u_tag;
  logic [PC_W-1:0]  f_seq;

  assign f_idx = fetch_pc_i[ALIGN_W +: IDX_W];
  assign f_tag = fetch_pc_i[PC_W-1 -: TAG_W];
  assign u_idx = upd_pc_i[ALIGN_W +: IDX_W];
  assign u_tag = upd_pc_i[PC_W-1 -: TAG_W];
  assign f_seq = fetch_pc_i + PC_W'(4);

  logic [N-1:0]            vld;
  logic [N-1:0][TAG_W-1:0] tag_a;
  logic [N-1:0][PC_W-1:0]  tgt_a;
  logic [N-1:0][1:0]       st_a;

  for (genvar i = 0; i < N; i++) begin : g_ent
    dir_e st_w;
    btb_entry #(.PC_W(PC_W), .TAG_W(TAG_W)) u_ent (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (upd_valid_i && (u_idx == IDX_W'(i))),
      .tag_i   (u_tag),
      .taken_i (upd_taken_i),
      .tgt_i   (upd_target_i),
      .vld_o   (vld[i]),
      .tag_o   (tag_a[i]),
      .tgt_o   (tgt_a[i]),
      .st_o    (st_w)
    );
    assign st_a[i] = st_w;
  end

  btb_lookup #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_look (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_i    (f_idx),
    .tag_i    (f_tag),
    .seq_pc_i (f_seq),
    .back_i   (fetch_back_i),
    .vld_i    (vld),
    .tag_a_i  (tag_a),
    .tgt_a_i  (tgt_a),
    .st_a_i   (st_a),
    .hit_o    (pred_hit_o),
    .taken_o  (pred_taken_o),
    .tgt_o    (pred_target_o)
  );

  // R1
  reset_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !pred_hit_o);

  // R9
  same_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_pc_i == fetch_pc_i && !pred_hit_o) |=>
      ($stable(fetch_pc_i) -> pred_hit_o));

endmodule

// File: tb/tb_btb_predictor.sv
module tb_btb_predictor;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] fetch_pc_i = '0;
  logic        fetch_back_i = 1'b0;
  logic        pred_hit_o, pred_taken_o;
  logic [31:0] pred_target_o;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_pc_i = '0;
  logic        upd_taken_i = 1'b0;
  logic [31:0] upd_target_i = '0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  btb_predictor dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .fetch_pc_i    (fetch_pc_i),
    .fetch_back_i  (fetch_back_i),
    .pred_hit_o    (pred_hit_o),
    .pred_taken_o  (pred_taken_o),
    .pred_target_o (pred_target_o),
    .upd_valid_i   (upd_valid_i),
    .upd_pc_i      (upd_pc_i),
    .upd_taken_i   (upd_taken_i),
    .upd_target_i  (upd_target_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] pc, input logic back);
    fetch_pc_i   = pc;
    fetch_back_i = back;
    #1;
  endtask

  task automatic resolve(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
    @(negedge clk);
    upd_valid_i  = 1'b1;
    upd_pc_i     = pc;
    upd_taken_i  = tk;
    upd_target_i = tgt;
    @(negedge clk);
    upd_valid_i  = 1'b0;
  endtask

  task automatic t_reset;
    look(32'h100, 1'b1); chk("R1 hit after reset", 32'(pred_hit_o), 32'd0);
    look(32'h104, 1'b0); chk("R1 hit after reset", 32'(pred_hit_o), 32'd0);
  endtask

  task automatic t_static;
    look(32'h3C, 1'b1);
    chk("R2 backward miss taken", 32'(pred_taken_o), 32'd1);
    chk("R2 miss target", pred_target_o, 32'h40);
    look(32'h3C, 1'b0);
    chk("R2 forward miss not taken", 32'(pred_taken_o), 32'd0);
    chk("R2 not-taken target", pred_target_o, 32'h40);
  endtask

  task automatic t_alloc;
    resolve(32'h100, 1'b1, 32'h80);
    look(32'h100, 1'b0);
    chk("R3 alloc hit", 32'(pred_hit_o), 32'd1);
    chk("R7 taken despite forward hint", 32'(pred_taken_o), 32'd1);
    chk("R3 alloc target", pred_target_o, 32'h80);
    resolve(32'h104, 1'b0, 32'h500);
    look(32'h104, 1'b1);
    chk("R3 alloc hit nt", 32'(pred_hit_o), 32'd1);
    chk("R7 not taken despite backward hint", 32'(pred_taken_o), 32'd0);
    chk("R2 hit not-taken target", pred_target_o, 32'h108);
  endtask

  task automatic t_walk;
    // entry 0x104 is Weakly Not Taken
    resolve(32'h104, 1'b0, 32'h0);
    resolve(32'h104, 1'b1, 32'h600);
    look(32'h104, 1'b0);
    chk("R5 WNT-N-SNT then T stays not taken", 32'(pred_taken_o), 32'd0);
    chk("R4 SNT+T predicts not taken", 32'(pred_hit_o), 32'd1);
    resolve(32'h104, 1'b1, 32'h600);
    look(32'h104, 1'b0);
    chk("R5 WNT+T predicts taken", 32'(pred_taken_o), 32'd1);
    chk("R5 WNT+T target", pred_target_o, 32'h600);
    resolve(32'h104, 1'b0, 32'h0);
    look(32'h104, 1'b1);
    chk("R5 WT+N predicts not taken", 32'(pred_taken_o), 32'd0);
    resolve(32'h104, 1'b1, 32'h600);
    resolve(32'h104, 1'b1, 32'h600);
    resolve(32'h104, 1'b0, 32'h0);
    look(32'h104, 1'b0);
    chk("R5 WT+T reaches strong taken", 32'(pred_taken_o), 32'd1);
  endtask

  task automatic t_saturate;
    // 0x100 is Weakly Taken
    resolve(32'h100, 1'b1, 32'h80);
    resolve(32'h100, 1'b1, 32'h80);
    resolve(32'h100, 1'b1, 32'h80);
    resolve(32'h100, 1'b0, 32'h0);
    look(32'h100, 1'b0);
    chk("R6 strong taken saturates", 32'(pred_taken_o), 32'd1);
    resolve(32'h100, 1'b0, 32'h0);
    look(32'h100, 1'b1);
    chk("R5 WT+N to WNT", 32'(pred_taken_o), 32'd0);
    resolve(32'h100, 1'b0, 32'h0);
    resolve(32'h100, 1'b0, 32'h0);
    resolve(32'h100, 1'b0, 32'h0);
    resolve(32'h100, 1'b1, 32'h80);
    look(32'h100, 1'b1);
    chk("R6 strong not taken saturates", 32'(pred_taken_o), 32'd0);
    resolve(32'h100, 1'b1, 32'h80);
    look(32'h100, 1'b0);
    chk("R5 back to taken", 32'(pred_taken_o), 32'd1);
  endtask

  task automatic t_target;
    // 0x100 is Weakly Taken
    resolve(32'h100, 1'b1, 32'h900);
    look(32'h100, 1'b0);
    chk("R10 taken resolve writes target", pred_target_o, 32'h900);
    resolve(32'h100, 1'b0, 32'hABC);
    look(32'h100, 1'b0);
    chk("R10 still taken", 32'(pred_taken_o), 32'd1);
    chk("R10 not-taken keeps target", pred_target_o, 32'h900);
  endtask

  task automatic t_conflict;
    look(32'h140, 1'b0);
    chk("R8 tag mismatch misses", 32'(pred_hit_o), 32'd0);
    chk("R8 miss uses hint", 32'(pred_taken_o), 32'd0);
    resolve(32'h140, 1'b1, 32'h1000);
    look(32'h140, 1'b0);
    chk("R8 replacement hit", 32'(pred_hit_o), 32'd1);
    chk("R8 replacement target", pred_target_o, 32'h1000);
    look(32'h100, 1'b0);
    chk("R8 old owner misses", 32'(pred_hit_o), 32'd0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    fetch_pc_i   = 32'h208;
    fetch_back_i = 1'b0;
    upd_valid_i  = 1'b1;
    upd_pc_i     = 32'h208;
    upd_taken_i  = 1'b1;
    upd_target_i = 32'h2000;
    #1;
    chk("R9 same cycle old hit", 32'(pred_hit_o), 32'd0);
    chk("R9 same cycle old direction", 32'(pred_taken_o), 32'd0);
    @(negedge clk);
    upd_valid_i = 1'b0;
    #1;
    chk("R9 next cycle hit", 32'(pred_hit_o), 32'd1);
    chk("R9 next cycle taken", 32'(pred_taken_o), 32'd1);
    chk("R9 next cycle target", pred_target_o, 32'h2000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_static();
    t_alloc();
    t_walk();
    t_saturate();
    t_target();
    t_conflict();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule